// File: doc/BRIEF.md
# SAR Conversion Timing Sequencer

This block paces one successive-approximation analog-to-digital conversion. It runs on a tick clock at twice the conversion-clock rate, so every phase length is a whole number of ticks; a length of 2.5 conversion cycles is 5 ticks. A one-tick start pulse begins a conversion. Two mode inputs are captured at that moment: one enables sample-and-hold and one selects 10-bit or 8-bit resolution. The block then drives the sampling switch, presents a trial code to an external DAC and strobes the external comparator decision at the close of every comparison. When the closing phase ends it publishes the result.

With sample-and-hold, the input is sampled only once, before the first bit. Without it, the input is re-sampled before every bit, and the first comparison and the closing phase have different lengths. The comparator, the capacitor array and the DAC sit outside the block. The comparator answer reaches the block as a plain digital level.

Top module: `sar_conv_sequencer`

## Requirements
- R1: With sample-and-hold enabled, busy stays high for exactly 56 ticks at 8-bit resolution and 66 ticks at 10-bit resolution.
- R2: With sample-and-hold disabled, busy stays high for exactly 98 ticks at 8-bit resolution and 118 ticks at 10-bit resolution.
- R3: Every conversion opens with a sampling phase of 8 ticks. The sampling-switch output is high during it, starting with the first busy tick.
- R4: The sampling-switch output is high for 8 ticks in total per conversion with sample-and-hold. Without it, the output is high for 8 + 5*(N-1) ticks, where N is the resolution, because each later bit has a 5-tick sampling phase. The output is never high in the same tick as the compare strobe.
- R5: The compare strobe pulses exactly N times per conversion, each time on the last tick of a comparison phase and only while busy. The first comparison lasts 5 ticks with sample-and-hold and 4 ticks without it, so the first strobe falls on busy tick 13 or 12 respectively. Every later comparison lasts 5 ticks.
- R6: The approximation runs from the most significant bit down. At each strobe the trial bit is kept when the comparator input is 1 and cleared when it is 0, and the next lower bit is then set for its trial. A comparator that answers (trial code <= V) yields the result V.
- R7: In 8-bit mode the result occupies bits 7:0 of the 10-bit output and bits 9:8 are zero.
- R8: Done pulses for exactly one tick, in the tick right after the last busy tick. The result output takes its new value in that same tick and holds it until the next conversion's done.
- R9: A start pulse that arrives while busy is ignored: the conversion in progress keeps its length, and no additional conversion or result follows.
- R10: Changes to the sample-and-hold or resolution inputs during a conversion have no effect on that conversion's timing or result.
- R11: After reset, busy, done, sampling switch and compare strobe are low, and the trial code and result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock at twice the conversion-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-tick request to begin a conversion |
| sh_en_i | input | 1 | 1 selects sample-and-hold, captured at start |
| res_wide_i | input | 1 | 1 selects 10-bit, 0 selects 8-bit, captured at start |
| cmp_i | input | 1 | Comparator decision: 1 keeps the trial bit |
| sample_en_o | output | 1 | Sampling switch enable |
| cmp_strobe_o | output | 1 | High in the tick at whose end cmp_i is taken |
| dac_code_o | output | 10 | Current trial code for the external DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-tick completion pulse |
| result_o | output | 10 | Last completed conversion result |

## Verification
The start pulse is taken at a rising edge, and busy and the sampling switch rise in the tick that follows. Strobes fall at fixed busy-tick offsets, and done and the new result appear exactly one tick after the last busy tick. The driver pushes, per conversion, the expected busy length, sampling-tick count, strobe count, first-strobe position and result into a queue. The monitor samples every output on the falling edge and counts ticks from the first busy tick. When it sees done, it pops the next expected item and compares it, so each value is judged exactly in the tick it is due. Between two done pulses the monitor also checks that the result has not changed.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_COMPARE = 2'd2,
    PH_CLOSE   = 2'd3
  } phase_e;
endpackage

// File: rtl/sar_tick_timer.sv
// Down-counter that measures one phase in ticks; expired when it reaches zero.
module sar_tick_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sar_phase_fsm.sv
// Walks sampling, comparison and closing phases; mode is latched at start.
module sar_phase_fsm
  import sar_seq_pkg::*;
#(
  parameter int RES_WIDTH            = 10,
  parameter int RES_NARROW           = 8,
  parameter int SAMPLE_FIRST_TICKS   = 8,
  parameter int SAMPLE_NEXT_TICKS    = 5,
  parameter int CMP_FIRST_NOSH_TICKS = 4,
  parameter int CMP_TICKS            = 5,
  parameter int CLOSE_NOSH_TICKS     = 16,
  parameter int CLOSE_SH_TICKS       = 8,
  parameter int CNT_W                = 5,
  parameter int IDX_W                = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sh_en_i,
  input  logic             res_wide_i,
  input  logic             tmr_zero_i,
  output phase_e           phase_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic [IDX_W-1:0] init_idx_o,
  output logic             sar_init_o,
  output logic             sar_step_o,
  output logic             capture_o
);
  localparam logic [IDX_W-1:0] IDX_WIDE   = IDX_W'(RES_WIDTH - 1);
  localparam logic [IDX_W-1:0] IDX_NARROW = IDX_W'(RES_NARROW - 1);
  localparam logic [CNT_W-1:0] LV_SAMP1   = CNT_W'(SAMPLE_FIRST_TICKS - 1);
  localparam logic [CNT_W-1:0] LV_SAMPN   = CNT_W'(SAMPLE_NEXT_TICKS - 1);
  localparam logic [CNT_W-1:0] LV_CMP1NS  = CNT_W'(CMP_FIRST_NOSH_TICKS - 1);
  localparam logic [CNT_W-1:0] LV_CMP     = CNT_W'(CMP_TICKS - 1);
  localparam logic [CNT_W-1:0] LV_CLS_NS  = CNT_W'(CLOSE_NOSH_TICKS - 1);
  localparam logic [CNT_W-1:0] LV_CLS_SH  = CNT_W'(CLOSE_SH_TICKS - 1);

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] bit_q, bit_d;
  logic             first_q, first_d;
  logic             sh_q, sh_d;
  logic             reg_en;

  assign init_idx_o = res_wide_i ? IDX_WIDE : IDX_NARROW;

  always_comb begin
    phase_d    = phase_q;
    bit_d      = bit_q;
    first_d    = first_q;
    sh_d       = sh_q;
    load_o     = 1'b0;
    load_val_o = '0;
    sar_init_o = 1'b0;
    sar_step_o = 1'b0;
    capture_o  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d    = PH_SAMPLE;
          sh_d       = sh_en_i;
          bit_d      = init_idx_o;
          first_d    = 1'b1;
          load_o     = 1'b1;
          load_val_o = LV_SAMP1;
          sar_init_o = 1'b1;
        end
      end
      PH_SAMPLE: begin
        if (tmr_zero_i) begin
          phase_d    = PH_COMPARE;
          load_o     = 1'b1;
          load_val_o = (first_q && !sh_q) ? LV_CMP1NS : LV_CMP;
        end
      end
      PH_COMPARE: begin
        if (tmr_zero_i) begin
          sar_step_o = 1'b1;
          first_d    = 1'b0;
          load_o     = 1'b1;
          if (bit_q == '0) begin
            phase_d    = PH_CLOSE;
            load_val_o = sh_q ? LV_CLS_SH : LV_CLS_NS;
          end else begin
            bit_d = bit_q - 1'b1;
            if (sh_q) begin
              load_val_o = LV_CMP;
            end else begin
              phase_d    = PH_SAMPLE;
              load_val_o = LV_SAMPN;
            end
          end
        end
      end
      PH_CLOSE: begin
        if (tmr_zero_i) begin
          phase_d   = PH_IDLE;
          capture_o = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign reg_en = (phase_q != PH_IDLE) || start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      first_q <= 1'b0;
      sh_q    <= 1'b0;
    end else if (reg_en) begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      first_q <= first_d;
      sh_q    <= sh_d;
    end
  end

  assign phase_o   = phase_q;
  assign bit_idx_o = bit_q;
endmodule

// File: rtl/sar_approx_reg.sv
// Trial code register, result register and completion pulse.
module sar_approx_reg #(
  parameter int RES_WIDTH = 10,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_i,
  input  logic [IDX_W-1:0]     init_idx_i,
  input  logic                 step_i,
  input  logic [IDX_W-1:0]     step_idx_i,
  input  logic                 cmp_i,
  input  logic                 capture_i,
  output logic [RES_WIDTH-1:0] trial_o,
  output logic [RES_WIDTH-1:0] result_o,
  output logic                 done_o
);
  logic [RES_WIDTH-1:0] trial_q, trial_d, result_q;
  logic                 trial_en, done_q;

  always_comb begin
    trial_d = trial_q;
    for (int i = 0; i < RES_WIDTH; i++) begin
      if (init_i) begin
        trial_d[i] = (i == int'(init_idx_i));
      end else if (step_i) begin
        if (i == int'(step_idx_i))                               trial_d[i] = cmp_i;
        else if ((step_idx_i != '0) && (i == int'(step_idx_i) - 1)) trial_d[i] = 1'b1;
      end
    end
  end

  assign trial_en = init_i || step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trial_q <= '0;
    else if (trial_en) trial_q <= trial_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result_q <= '0;
    else if (capture_i) result_q <= trial_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= capture_i;
  end

  assign trial_o  = trial_q;
  assign result_o = result_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
  import sar_seq_pkg::*;
#(
  parameter int RES_WIDTH            = 10,
  parameter int RES_NARROW           = 8,
  parameter int SAMPLE_FIRST_TICKS   = 8,
  parameter int SAMPLE_NEXT_TICKS    = 5,
  parameter int CMP_FIRST_NOSH_TICKS = 4,
  parameter int CMP_TICKS            = 5,
  parameter int CLOSE_NOSH_TICKS     = 16,
  parameter int CLOSE_SH_TICKS       = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 sh_en_i,
  input  logic                 res_wide_i,
  input  logic                 cmp_i,
  output logic                 sample_en_o,
  output logic                 cmp_strobe_o,
  output logic [RES_WIDTH-1:0] dac_code_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [RES_WIDTH-1:0] result_o
);
  localparam int MAX_TICKS = (CLOSE_NOSH_TICKS > SAMPLE_FIRST_TICKS) ? CLOSE_NOSH_TICKS
                                                                    : SAMPLE_FIRST_TICKS;
  localparam int CNT_W = $clog2(MAX_TICKS) + 1;
  localparam int IDX_W = $clog2(RES_WIDTH);

  logic             rst_s1_q, rst_s2_q;
  phase_e           phase;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic [IDX_W-1:0] bit_idx, init_idx;
  logic             sar_init, sar_step, capture;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  sar_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sar_phase_fsm #(
    .RES_WIDTH            (RES_WIDTH),
    .RES_NARROW           (RES_NARROW),
    .SAMPLE_FIRST_TICKS   (SAMPLE_FIRST_TICKS),
    .SAMPLE_NEXT_TICKS    (SAMPLE_NEXT_TICKS),
    .CMP_FIRST_NOSH_TICKS (CMP_FIRST_NOSH_TICKS),
    .CMP_TICKS            (CMP_TICKS),
    .CLOSE_NOSH_TICKS     (CLOSE_NOSH_TICKS),
    .CLOSE_SH_TICKS       (CLOSE_SH_TICKS),
    .CNT_W                (CNT_W),
    .IDX_W                (IDX_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .start_i    (start_i),
    .sh_en_i    (sh_en_i),
    .res_wide_i (res_wide_i),
    .tmr_zero_i (tmr_zero),
    .phase_o    (phase),
    .load_o     (tmr_load),
    .load_val_o (tmr_val),
    .bit_idx_o  (bit_idx),
    .init_idx_o (init_idx),
    .sar_init_o (sar_init),
    .sar_step_o (sar_step),
    .capture_o  (capture)
  );

  sar_approx_reg #(.RES_WIDTH(RES_WIDTH), .IDX_W(IDX_W)) u_sar (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .init_i     (sar_init),
    .init_idx_i (init_idx),
    .step_i     (sar_step),
    .step_idx_i (bit_idx),
    .cmp_i      (cmp_i),
    .capture_i  (capture),
    .trial_o    (dac_code_o),
    .result_o   (result_o),
    .done_o     (done_o)
  );

  assign busy_o       = (phase != PH_IDLE);
  assign sample_en_o  = (phase == PH_SAMPLE);
  assign cmp_strobe_o = (phase == PH_COMPARE) && tmr_zero;
endmodule

// File: rtl/sar_conv_sequencer_checker.sv
module sar_conv_sequencer_checker #(
  parameter int RES_WIDTH            = 10,
  parameter int RES_NARROW           = 8,
  parameter int SAMPLE_FIRST_TICKS   = 8,
  parameter int SAMPLE_NEXT_TICKS    = 5,
  parameter int CMP_FIRST_NOSH_TICKS = 4,
  parameter int CMP_TICKS            = 5,
  parameter int CLOSE_NOSH_TICKS     = 16,
  parameter int CLOSE_SH_TICKS       = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sample_en_o,
  input logic                 cmp_strobe_o,
  input logic                 busy_o,
  input logic                 done_o,
  input logic [RES_WIDTH-1:0] result_o
);
  localparam int TOT_SH_W = SAMPLE_FIRST_TICKS + CMP_TICKS * RES_WIDTH + CLOSE_SH_TICKS;
  localparam int TOT_SH_N = SAMPLE_FIRST_TICKS + CMP_TICKS * RES_NARROW + CLOSE_SH_TICKS;
  localparam int TOT_NS_W = SAMPLE_FIRST_TICKS + CMP_FIRST_NOSH_TICKS
                          + (RES_WIDTH - 1) * (SAMPLE_NEXT_TICKS + CMP_TICKS) + CLOSE_NOSH_TICKS;
  localparam int TOT_NS_N = SAMPLE_FIRST_TICKS + CMP_FIRST_NOSH_TICKS
                          + (RES_NARROW - 1) * (SAMPLE_NEXT_TICKS + CMP_TICKS) + CLOSE_NOSH_TICKS;

  logic [15:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (busy_o) len_q <= len_q + 16'd1;
    else             len_q <= '0;
  end

  // R1 and R2: busy window length is one of the four fixed totals
  assert_busy_total_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (int'(len_q) == TOT_SH_W || int'(len_q) == TOT_SH_N ||
                       int'(len_q) == TOT_NS_W || int'(len_q) == TOT_NS_N));

  assert_switch_vs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |-> !cmp_strobe_o);

  assert_strobe_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe_o |-> busy_o);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
endmodule

bind sar_conv_sequencer sar_conv_sequencer_checker #(
  .RES_WIDTH            (RES_WIDTH),
  .RES_NARROW           (RES_NARROW),
  .SAMPLE_FIRST_TICKS   (SAMPLE_FIRST_TICKS),
  .SAMPLE_NEXT_TICKS    (SAMPLE_NEXT_TICKS),
  .CMP_FIRST_NOSH_TICKS (CMP_FIRST_NOSH_TICKS),
  .CMP_TICKS            (CMP_TICKS),
  .CLOSE_NOSH_TICKS     (CLOSE_NOSH_TICKS),
  .CLOSE_SH_TICKS       (CLOSE_SH_TICKS)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_en_o  (sample_en_o),
  .cmp_strobe_o (cmp_strobe_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .result_o     (result_o)
);

// File: tb/sar_conv_sequencer_tb.sv
`timescale 1ns/1ps
module sar_conv_sequencer_tb;
  logic       clk, rst_n, start, sh_en, res_wide, cmp;
  logic       sample_en, cmp_strobe, busy, done;
  logic [9:0] dac_code, result;
  logic [9:0] target;

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct {
    logic [9:0] res;
    int         busy_len;
    int         samp_len;
    int         strobes;
    int         first_at;
  } exp_t;
  exp_t exp_q[$];

  sar_conv_sequencer u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .sh_en_i      (sh_en),
    .res_wide_i   (res_wide),
    .cmp_i        (cmp),
    .sample_en_o  (sample_en),
    .cmp_strobe_o (cmp_strobe),
    .dac_code_o   (dac_code),
    .busy_o       (busy),
    .done_o       (done),
    .result_o     (result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // comparator model: keep the trial bit while trial <= target
  always_comb cmp = (dac_code <= target);

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor / scoreboard
  bit         mon_on = 1'b0;
  int         c_busy = 0, c_samp = 0, c_strb = 0, c_first = 0;
  logic [9:0] last_res = '0;
  bit         hold_bad = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (busy) c_busy++;
      if (sample_en) c_samp++;
      if (cmp_strobe) begin
        c_strb++;
        if (c_strb == 1) c_first = c_busy;
      end
      if (c_busy == 1 && busy) chk(sample_en === 1'b1, "R3 switch on first busy tick", int'(sample_en), 1);
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(c_busy == e.busy_len, "R1/R2 busy length", c_busy, e.busy_len);
          chk(c_samp == e.samp_len, "R4 sampling ticks", c_samp, e.samp_len);
          chk(c_strb == e.strobes,  "R5 strobe count", c_strb, e.strobes);
          chk(c_first == e.first_at, "R5 first strobe tick", c_first, e.first_at);
          chk(result === e.res, "R6/R7 result", int'(result), int'(e.res));
          chk(!hold_bad, "R8 result held between completions", int'(hold_bad), 0);
        end
        c_busy = 0; c_samp = 0; c_strb = 0; c_first = 0;
        last_res = result;
        hold_bad = 1'b0;
      end else if (result !== last_res) begin
        hold_bad = 1'b1;
      end
    end
  end

  task automatic run_conv(input bit sh, input bit wide, input int tgt, input bit disturb);
    exp_t e;
    int   n;
    n          = wide ? 10 : 8;
    e.res      = wide ? tgt[9:0] : {2'b00, tgt[7:0]};
    e.busy_len = sh ? (wide ? 66 : 56) : (wide ? 118 : 98);
    e.samp_len = sh ? 8 : 8 + 5 * (n - 1);
    e.strobes  = n;
    e.first_at = sh ? 13 : 12;
    @(negedge clk);
    sh_en    = sh;
    res_wide = wide;
    target   = e.res;
    start    = 1'b1;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R9 and R10: restart request and mode flips while busy
      repeat (20) @(negedge clk);
      start    = 1'b1;
      sh_en    = !sh;
      res_wide = !wide;
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (!done);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R9 no extra conversion after completion", int'(busy), 0);
  endtask

  task automatic main_seq();
    rst_n = 1'b0; start = 1'b0; sh_en = 1'b0; res_wide = 1'b0; target = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy === 1'b0,       "R11 busy", int'(busy), 0);
    chk(done === 1'b0,       "R11 done", int'(done), 0);
    chk(sample_en === 1'b0,  "R11 switch", int'(sample_en), 0);
    chk(cmp_strobe === 1'b0, "R11 strobe", int'(cmp_strobe), 0);
    chk(dac_code === '0,     "R11 trial code", int'(dac_code), 0);
    chk(result === '0,       "R11 result", int'(result), 0);
    mon_on = 1'b1;
    // R1 with sample-and-hold
    run_conv(1'b1, 1'b1, 10'h2AA, 1'b0);
    run_conv(1'b1, 1'b1, 10'h3FF, 1'b0);
    run_conv(1'b1, 1'b0, 8'h5A, 1'b0);
    run_conv(1'b1, 1'b0, 0, 1'b0);
    // R2 without sample-and-hold
    run_conv(1'b0, 1'b1, 10'h155, 1'b0);
    run_conv(1'b0, 1'b1, 0, 1'b0);
    run_conv(1'b0, 1'b0, 8'hFF, 1'b0);
    run_conv(1'b0, 1'b0, 8'h81, 1'b0);
    // R7 narrow with wide-looking target bits above 7 masked off
    run_conv(1'b1, 1'b0, 10'h37E, 1'b0);
    // R9 / R10 disturbed conversions
    run_conv(1'b1, 1'b0, 8'h3C, 1'b1);
    run_conv(1'b0, 1'b1, 10'h201, 1'b1);
    run_conv(1'b0, 1'b0, 8'hC3, 1'b1);
    run_conv(1'b1, 1'b1, 10'h001, 1'b1);
    chk(exp_q.size() == 0, "R8 every conversion completed", exp_q.size(), 0);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule